// File: doc/BRIEF.md
# Device INTx to PIRQ Mapper

This block keeps, for every device slot on a PCI bus segment, the choice of which of eight shared interrupt lines (PIRQ A to H, encoded 0 to 7) each of the slot's four interrupt pins drives. A host writes and reads a small byte-addressed register window to change the routing. Interrupt logic elsewhere asks a combinational lookup port which PIRQ a given (slot, pin) pair lands on.

Seven slots, 25 to 31, own a 16-bit routing register. Slot 30 is hard-wired so that pins A to D reach PIRQ E to H, and its register always reads zero. Every slot without a register follows a rotating default that stays within the upper four PIRQs. Every write access raises a one-cycle change pulse, so that any cached interrupt routes can be refreshed.

Top module: `intx_pirq_router`

## Requirements
- R1: After reset, every routing register except slot 30's reads 16'h3210, so pin p of such a slot looks up PIRQ p.
- R2: The register of slot 25+k occupies window bytes 2k (low byte) and 2k+1. The field for pin p (0=INTA to 3=INTD) is bits [4p+3:4p] of that 16-bit value.
- R3: A lookup on a slot that owns a writable register returns the low 3 bits of the pin's field. Bit 3 of the field has no effect.
- R4: Slot 30's register bytes (window offsets 10 and 11) always read zero and ignore writes. Lookup of pin p on slot 30 returns PIRQ 4+p.
- R5: A lookup on a slot outside 25 to 31 returns PIRQ ((slot + pin) mod 4) + 4.
- R6: Only the low 4 bits of the host address select the window byte. Higher address bits are ignored.
- R7: Data lane i (bits [8i+7:8i]) belongs to window byte addr+i and takes part only when its byte enable be[i] is set. A lane whose byte would lie at or past offset 16 is dropped on writes and reads as zero.
- R8: Window bytes 14 and 15 hold no register. They read zero and ignore writes.
- R9: route_chg is high for exactly the one cycle after each write request, including a write with no byte enables, and low otherwise. A lookup made in that cycle already shows the new routing.
- R10: Read data and rvalid appear in the cycle after a read request. Lanes that are not enabled read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request for one cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Host byte address; masked to the window |
| be | input | 4 | Byte enables, lane i at addr+i |
| wdata | input | 32 | Write data, little-endian lanes |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid |
| route_chg | output | 1 | One-cycle pulse after a write |
| lk_slot | input | 5 | Lookup slot number |
| lk_pin | input | 2 | Lookup pin, 0=INTA to 3=INTD |
| lk_pirq | output | 3 | PIRQ index, 0=A to 7=H |

## Verification
The bench sweeps every slot and pin through the lookup after reset and after each routing change. A design that confuses the fixed slot with a writable one, or that rotates the default wrongly, shows a wrong PIRQ on exactly those slots. Writes are aimed at the fixed slot's bytes, at the unused tail, at addresses with high bits set and across the end of the window. A decoder that failed to mask the address or to drop overflowing lanes would corrupt neighbouring registers or return stale bytes. Field values with bit 3 set catch a lookup that uses four bits, and a write with no byte enables checks that the change pulse still fires while nothing is stored.

// File: rtl/pirq_route_pkg.sv
`timescale 1ns/1ps
package pirq_route_pkg;
  localparam int PINS    = 4;
  localparam int PIN_W   = 2;
  localparam int PIRQ_W  = 3;
  localparam int FIELD_W = 4;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = PINS * FIELD_W;

  typedef logic [PIRQ_W-1:0] pirq_t;

  // default for slots without a register: rotate, upper half only
  function automatic pirq_t rotate_default(input int unsigned slot, input int unsigned pin);
    return pirq_t'(((slot + pin) % 4) + 4);
  endfunction

  // hard-wired slot: pin p drives upper PIRQ 4+p
  function automatic pirq_t fixed_upper(input int unsigned pin);
    return pirq_t'(pin + 4);
  endfunction
endpackage

// File: rtl/pirq_win_lanes.sv
`timescale 1ns/1ps
module pirq_win_lanes #(
  parameter int WIN_AW = 4,
  parameter int LANES  = 4
) (
  input  logic [WIN_AW-1:0]       base,
  input  logic [LANES-1:0]        be,
  output logic [LANES-1:0]        lane_ok,
  output logic [LANES*WIN_AW-1:0] lane_off
);
  localparam int SUM_W = WIN_AW + 1;

  // per-lane offset; the carry bit marks a lane past the window end
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [SUM_W-1:0] sum;
    assign sum = {1'b0, base} + SUM_W'(g);
    assign lane_ok[g] = be[g] & ~sum[WIN_AW];
    assign lane_off[g*WIN_AW +: WIN_AW] = sum[WIN_AW-1:0];
  end
endmodule

// File: rtl/pirq_route_regs.sv
`timescale 1ns/1ps
module pirq_route_regs #(
  parameter int          WIN_AW       = 4,
  parameter int          LANES        = 4,
  parameter int          REG_CNT      = 7,
  parameter int          FIXED_IDX    = 5,
  parameter logic [15:0] DEFAULT_WORD = 16'h3210
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req,
  input  logic                    we,
  input  logic [LANES-1:0]        lane_ok,
  input  logic [LANES*WIN_AW-1:0] lane_off,
  input  logic [8*LANES-1:0]      wdata,
  output logic [8*LANES-1:0]      rdata,
  output logic                    rvalid,
  output logic                    route_chg,
  output logic [REG_CNT*16-1:0]   route_words
);
  localparam int REG_BYTES = 2 * REG_CNT;
  localparam int DW        = 8 * LANES;

  logic [7:0] mem [REG_BYTES];
  logic [DW-1:0] rd_next;

  function automatic logic holds_reg(input logic [WIN_AW-1:0] off);
    return int'(off) < REG_BYTES;
  endfunction

  function automatic logic storable(input logic [WIN_AW-1:0] off);
    return holds_reg(off) && ((int'(off) / 2) != FIXED_IDX);
  endfunction

  function automatic logic [7:0] reset_byte(input int b);
    if ((b / 2) == FIXED_IDX) return 8'h00;
    return (b % 2 == 1) ? DEFAULT_WORD[15:8] : DEFAULT_WORD[7:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < REG_BYTES; b++) mem[b] <= reset_byte(b);
    end else if (req && we) begin
      for (int i = 0; i < LANES; i++) begin
        if (lane_ok[i] && storable(lane_off[i*WIN_AW +: WIN_AW]))
          mem[lane_off[i*WIN_AW +: WIN_AW]] <= wdata[8*i +: 8];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_ok[i] && holds_reg(lane_off[i*WIN_AW +: WIN_AW]))
        rd_next[8*i +: 8] = mem[lane_off[i*WIN_AW +: WIN_AW]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      rvalid    <= 1'b0;
      route_chg <= 1'b0;
    end else begin
      rvalid    <= req && !we;
      route_chg <= req && we;
      if (req && !we) rdata <= rd_next;
    end
  end

  for (genvar k = 0; k < REG_CNT; k++) begin : g_word
    assign route_words[16*k +: 16] = {mem[2*k+1], mem[2*k]};
  end
endmodule

// File: rtl/pirq_slot_lookup.sv
`timescale 1ns/1ps
module pirq_slot_lookup
  import pirq_route_pkg::*;
#(
  parameter int SLOT_W     = 5,
  parameter int REG_FIRST  = 25,
  parameter int REG_CNT    = 7,
  parameter int FIXED_SLOT = 30
) (
  input  logic [SLOT_W-1:0]     slot,
  input  logic [PIN_W-1:0]      pin,
  input  logic [REG_CNT*16-1:0] route_words,
  output pirq_t                 pirq
);
  int unsigned s_i;
  int unsigned p_i;
  int unsigned bit_i;

  always_comb begin
    s_i   = int'(slot);
    p_i   = int'(pin);
    bit_i = 0;
    if (s_i >= REG_FIRST && s_i < REG_FIRST + REG_CNT) begin
      if (s_i == FIXED_SLOT) begin
        pirq = fixed_upper(p_i);
      end else begin
        bit_i = (s_i - REG_FIRST) * WORD_W + p_i * FIELD_W;
        pirq  = route_words[bit_i +: PIRQ_W];
      end
    end else begin
      pirq = rotate_default(s_i, p_i);
    end
  end
endmodule

// File: rtl/intx_pirq_router.sv
`timescale 1ns/1ps
module intx_pirq_router
  import pirq_route_pkg::*;
#(
  parameter int          HOST_AW      = 12,
  parameter int          WIN_AW       = 4,
  parameter int          LANES        = 4,
  parameter int          SLOT_W       = 5,
  parameter int          REG_FIRST    = 25,
  parameter int          REG_CNT      = 7,
  parameter int          FIXED_SLOT   = 30,
  parameter logic [15:0] DEFAULT_WORD = 16'h3210
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req,
  input  logic               we,
  input  logic [HOST_AW-1:0] addr,
  input  logic [LANES-1:0]   be,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] rdata,
  output logic               rvalid,
  output logic               route_chg,
  input  logic [SLOT_W-1:0]  lk_slot,
  input  logic [1:0]         lk_pin,
  output logic [2:0]         lk_pirq
);
  localparam int FIXED_IDX = FIXED_SLOT - REG_FIRST;

  logic [WIN_AW-1:0]        win_base;
  logic [LANES-1:0]         lane_ok;
  logic [LANES*WIN_AW-1:0]  lane_off;
  logic [REG_CNT*16-1:0]    route_words;
  logic                     unused_addr_hi;

  assign win_base       = addr[WIN_AW-1:0];
  assign unused_addr_hi = ^addr[HOST_AW-1:WIN_AW];

  pirq_win_lanes #(.WIN_AW(WIN_AW), .LANES(LANES)) u_lanes (
    .base(win_base), .be(be), .lane_ok(lane_ok), .lane_off(lane_off)
  );

  pirq_route_regs #(
    .WIN_AW(WIN_AW), .LANES(LANES), .REG_CNT(REG_CNT),
    .FIXED_IDX(FIXED_IDX), .DEFAULT_WORD(DEFAULT_WORD)
  ) u_regs (
    .clk(clk), .rst(rst), .req(req), .we(we),
    .lane_ok(lane_ok), .lane_off(lane_off), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .route_chg(route_chg),
    .route_words(route_words)
  );

  pirq_slot_lookup #(
    .SLOT_W(SLOT_W), .REG_FIRST(REG_FIRST), .REG_CNT(REG_CNT),
    .FIXED_SLOT(FIXED_SLOT)
  ) u_lookup (
    .slot(lk_slot), .pin(lk_pin), .route_words(route_words), .pirq(lk_pirq)
  );
endmodule

// File: rtl/intx_pirq_router_chk.sv
`timescale 1ns/1ps
module intx_pirq_router_chk #(
  parameter int LANES      = 4,
  parameter int SLOT_W     = 5,
  parameter int REG_FIRST  = 25,
  parameter int REG_CNT    = 7,
  parameter int FIXED_SLOT = 30
) (
  input logic               clk,
  input logic               rst,
  input logic               req,
  input logic               we,
  input logic [LANES-1:0]   be,
  input logic [8*LANES-1:0] rdata,
  input logic               rvalid,
  input logic               route_chg,
  input logic [SLOT_W-1:0]  lk_slot,
  input logic [1:0]         lk_pin,
  input logic [2:0]         lk_pirq
);
  AST_CHG_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req && we) |=> route_chg); // R9
  AST_CHG_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(req && we) |=> !route_chg); // R9
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (req && !we) |=> rvalid); // R10
  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    !(req && !we) |=> !rvalid); // R10
  AST_NO_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (req && !we && be == '0) |=> (rdata == '0)); // R10
  AST_FIXED_SLOT_UPPER: assert property (@(posedge clk) disable iff (rst)
    (int'(lk_slot) == FIXED_SLOT) |-> (lk_pirq == {1'b1, lk_pin})); // R4
  AST_ROTATE_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (int'(lk_slot) < REG_FIRST || int'(lk_slot) >= REG_FIRST + REG_CNT)
    |-> (lk_pirq == {1'b1, 2'(lk_slot + SLOT_W'(lk_pin))})); // R5
endmodule

bind intx_pirq_router intx_pirq_router_chk #(
  .LANES(LANES), .SLOT_W(SLOT_W), .REG_FIRST(REG_FIRST),
  .REG_CNT(REG_CNT), .FIXED_SLOT(FIXED_SLOT)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .we(we), .be(be), .rdata(rdata),
  .rvalid(rvalid), .route_chg(route_chg), .lk_slot(lk_slot),
  .lk_pin(lk_pin), .lk_pirq(lk_pirq)
);

// File: tb/intx_pirq_router_tb.sv
`timescale 1ns/1ps
module intx_pirq_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we  = 1'b0;
  logic [11:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        route_chg;
  logic [4:0]  lk_slot = '0;
  logic [1:0]  lk_pin = '0;
  logic [2:0]  lk_pirq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // 250 MHz
  always #2 clk = ~clk;

  intx_pirq_router u_dut (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .route_chg(route_chg),
    .lk_slot(lk_slot), .lk_pin(lk_pin), .lk_pirq(lk_pirq)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]  mdl [16];
  logic        exp_chg = 1'b0;
  logic        exp_rv  = 1'b0;
  logic [31:0] exp_rd  = '0;

  function automatic logic [7:0] def_byte(input int b);
    if (b == 10 || b == 11 || b >= 14) return 8'h00;
    return (b % 2 == 1) ? 8'h32 : 8'h10;
  endfunction

  function automatic logic [2:0] model_lk(input int s, input int p);
    int k;
    logic [15:0] w;
    if (s == 30) return 3'(4 + p);
    if (s >= 25 && s <= 31) begin
      k = s - 25;
      w = {mdl[2*k+1], mdl[2*k]};
      return 3'((w >> (4*p)) & 16'h7);
    end
    return 3'(((s + p) % 4) + 4);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 16; b++) mdl[b] = def_byte(b);
      exp_chg <= 1'b0;
      exp_rv  <= 1'b0;
      exp_rd  <= '0;
    end else begin
      exp_chg <= req && we;
      exp_rv  <= req && !we;
      if (req && !we) begin
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
          int off;
          off = (int'(addr) % 16) + i;
          if (be[i] && off < 16) r[8*i +: 8] = mdl[off];
        end
        exp_rd <= r;
      end
      if (req && we) begin
        for (int i = 0; i < 4; i++) begin
          int off;
          off = (int'(addr) % 16) + i;
          if (be[i] && off < 14 && off != 10 && off != 11)
            mdl[off] = wdata[8*i +: 8];
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // clock-by-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R9 route_chg", {31'b0, route_chg}, {31'b0, exp_chg});
      chk("R10 rvalid", {31'b0, rvalid}, {31'b0, exp_rv});
      if (exp_rv) chk("R10 rdata", rdata, exp_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [11:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R9 pulse high after write", {31'b0, route_chg}, 32'd1);
  endtask

  task automatic rd(input logic [11:0] a, input logic [3:0] b, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a; be = b;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic look(input string tag, input int s, input int p, input logic [2:0] exp);
    @(negedge clk);
    lk_slot = 5'(s); lk_pin = 2'(p);
    #1;
    chk(tag, {29'b0, lk_pirq}, {29'b0, exp});
  endtask

  task automatic sweep();
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        string tag;
        if (s == 30) tag = "R4 fixed slot lookup";
        else if (s >= 25) tag = "R3 register slot lookup";
        else tag = "R5 rotating default lookup";
        look(tag, s, p, model_lk(s, p));
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1 R2: defaults after reset
    rd(12'h000, 4'hF, d); chk("R1 slot25/26 default", d, 32'h3210_3210);
    rd(12'h008, 4'hF, d); chk("R4 slot30 reads zero", d, 32'h0000_3210);
    rd(12'h00C, 4'hF, d); chk("R8 unused tail reads zero", d, 32'h0000_3210);
    look("R1 default pin C", 25, 2, 3'd2);
    look("R4 slot30 pin A", 30, 0, 3'd4);
    look("R5 slot3 pin C", 3, 2, 3'd5);
    sweep();

    // R2 R3: field layout, bit 3 ignored
    wr(12'h000, 4'b0011, 32'h0000_F7A5);
    look("R3 bit3 ignored pin B", 25, 1, 3'd2);
    look("R2 pin D field", 25, 3, 3'd7);
    rd(12'h000, 4'hF, d); chk("R2 readback", d, 32'h3210_F7A5);

    // R6: high address bits ignored
    wr(12'h102, 4'b0011, 32'h0000_0123);
    rd(12'h002, 4'b0011, d); chk("R6 masked address", d, 32'h0000_0123);
    look("R6 slot26 pin A", 26, 0, 3'd3);

    // R4: fixed slot ignores writes
    wr(12'h00A, 4'b0011, 32'h0000_FFFF);
    rd(12'h00A, 4'b0011, d); chk("R4 write ignored", d, 32'h0);
    look("R4 pin B after write", 30, 1, 3'd5);

    // R7 R8: lanes across window end, tail bytes
    wr(12'h00D, 4'hF, 32'hAABB_CCDD);
    rd(12'h00C, 4'hF, d); chk("R8 tail write ignored", d, 32'h0000_DD10);
    rd(12'h00D, 4'hF, d); chk("R7 overflow lanes zero", d, 32'h0000_00DD);
    rd(12'h00F, 4'hF, d); chk("R7 last byte only", d, 32'h0);

    // R7: sparse byte enables
    wr(12'h004, 4'b0101, 32'h1122_3344);
    rd(12'h004, 4'hF, d); chk("R7 sparse lanes", d, 32'h3222_3244);

    // R9: write with no enables pulses, stores nothing
    wr(12'h000, 4'b0000, 32'hFFFF_FFFF);
    rd(12'h000, 4'hF, d); chk("R9 empty write no effect", d, 32'h0123_F7A5);
    rd(12'h000, 4'b0000, d); chk("R10 no lanes read zero", d, 32'h0);

    // R9: back-to-back writes keep the pulse up
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'h008; be = 4'b0011; wdata = 32'h0000_4567;
    @(negedge clk);
    addr = 12'h00C; wdata = 32'h0000_0765;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    chk("R9 pulse on second write", {31'b0, route_chg}, 32'd1);
    @(negedge clk);
    chk("R9 pulse ends", {31'b0, route_chg}, 32'd0);
    look("R9 new route visible", 31, 2, 3'd7);
    sweep();

    // R1: reset restores defaults
    do_reset();
    rd(12'h000, 4'hF, d); chk("R1 defaults after second reset", d, 32'h3210_3210);
    sweep();

    repeat (2) @(negedge clk);
    summary();
  end
endmodule